// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This combinational block sits right after the instruction fetch port. It receives six bytes that were fetched starting at the current program counter, plus the program counter itself. From these it produces the instruction's opcode and function nibbles, its two register specifiers and its 32-bit constant. It also produces the instruction's length in bytes and the address of the instruction that follows in sequence.

The length is between one and six bytes and depends only on the opcode nibble of the first byte. The opcode nibble also decides whether a register-specifier byte and a constant word are present. The constant is little-endian. It begins right after the register byte when that byte is present, and right after the first byte otherwise.

Flags report whether a register byte and a constant are present. A separate flag marks opcodes that are not defined. Fields that an instruction does not carry are driven to fixed values, so downstream logic never sees leftover fetch bytes. Memory access, program-counter selection, branch resolution and execution belong to other blocks.

Top module: `fetch_decode`

## Requirements
- R1: Byte k of the window occupies bits [8k+7:8k], and byte 0 is at the PC. `icode` is bits [7:4] of byte 0 and `ifun` is bits [3:0] of byte 0, for every opcode.
- R2: `ilen` follows the opcode:
  - opcodes 0x0 (nop), 0x1 (halt) and 0x9 (ret) give 1;
  - opcodes 0x2 (register move), 0x6 (ALU op), 0xA (push) and 0xB (pop) give 2;
  - opcodes 0x7 (jump) and 0x8 (call) give 5;
  - opcodes 0x3 (immediate move), 0x4 (store) and 0x5 (load) give 6.
- R3: When a register byte is present, `ra` is bits [7:4] of byte 1 and `rb` is bits [3:0] of byte 1.
- R4: When no register byte is present, `ra` and `rb` are both 4'h8, the "no register" ID.
- R5: For opcodes 0x7 and 0x8, `valc` is bytes 1 to 4 of the window read little-endian, with byte 1 as the least significant byte. The value is an absolute address and is passed through unchanged.
- R6: For opcodes 0x3, 0x4 and 0x5, `valc` is bytes 2 to 5 of the window read little-endian, with byte 2 as the least significant byte.
- R7: When no constant is present, `valc` is 0.
- R8: `next_pc` equals `pc + ilen` modulo 2^32, including when the sum passes 0xFFFFFFFF.
- R9: For opcodes 0xC to 0xF, `bad_op` is 1, `ilen` is 1, `valc` is 0, both presence flags are 0, and `ra`/`rb` are 4'h8. For every other opcode, `bad_op` is 0.
- R10: `has_regs` is 1 exactly for opcodes 0x2 to 0x6, 0xA and 0xB. `has_const` is 1 exactly for opcodes 0x3, 0x4, 0x5, 0x7 and 0x8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc | input | 32 | Address of byte 0 of the window |
| window | input | 48 | Fetched bytes; byte k at bits [8k+7:8k] |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function nibble |
| ra | output | 4 | First register specifier, or 4'h8 |
| rb | output | 4 | Second register specifier, or 4'h8 |
| valc | output | 32 | Constant word, or 0 |
| ilen | output | 3 | Instruction length in bytes |
| next_pc | output | 32 | Address of the next sequential instruction |
| has_regs | output | 1 | Register byte present |
| has_const | output | 1 | Constant word present |
| bad_op | output | 1 | Opcode not defined |

## Verification
The hardest thing to expose is a field that leaks from the wrong byte. For example, the constant could be taken at the wrong offset, or trailing fetch bytes could reach `valc` or the register outputs of a short or undefined instruction. With ordinary zero-padded code, such a leak produces a plausible value and goes unnoticed. The stimulus therefore sweeps every opcode and function pair and fills all six bytes from a pseudo-random generator, so any byte that reaches an output where it should not will be nonzero and distinct. The PC is placed just below 2^32 for part of the sweep, which forces the next-address sum to wrap. The three known encodings are also checked field by field.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int WORD_W    = 32;
  localparam int WORD_B    = WORD_W / 8;
  localparam int WIN_BYTES = 2 + WORD_B;
  localparam int WIN_W     = 8 * WIN_BYTES;
  localparam int LEN_W     = $clog2(WIN_BYTES + 1);
  localparam logic [3:0] REG_NONE = 4'h8;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_HALT  = 4'h1,
    OP_RRMOV = 4'h2,
    OP_IRMOV = 4'h3,
    OP_RMMOV = 4'h4,
    OP_MRMOV = 4'h5,
    OP_ALU   = 4'h6,
    OP_JMP   = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;
endpackage

// File: rtl/fd_class.sv
module fd_class
  import fd_pkg::*;
(
  input  logic [3:0]       icode,
  output logic             has_regs,
  output logic             has_const,
  output logic             bad_op,
  output logic [LEN_W-1:0] ilen
);
  always_comb begin
    has_regs  = 1'b0;
    has_const = 1'b0;
    bad_op    = 1'b0;
    case (opcode_e'(icode))
      OP_NOP, OP_HALT, OP_RET: ;
      OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: has_regs = 1'b1;
      OP_JMP, OP_CALL: has_const = 1'b1;
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        has_regs  = 1'b1;
        has_const = 1'b1;
      end
      default: bad_op = 1'b1;
    endcase
    ilen = LEN_W'(1) + LEN_W'(has_regs) + (has_const ? LEN_W'(WORD_B) : LEN_W'(0));
  end
endmodule

// File: rtl/fd_extract.sv
module fd_extract
  import fd_pkg::*;
(
  input  logic [WIN_W-9:0]  tail,
  input  logic              has_regs,
  input  logic              has_const,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [WORD_W-1:0] valc
);
  localparam int SHORT_LO = 0;
  localparam int LONG_LO  = 8;

  logic [WORD_W-1:0] const_short;
  logic [WORD_W-1:0] const_long;

  assign const_short = tail[SHORT_LO +: WORD_W];
  assign const_long  = tail[LONG_LO  +: WORD_W];

  always_comb begin
    ra = has_regs ? tail[7:4] : REG_NONE;
    rb = has_regs ? tail[3:0] : REG_NONE;
    if (!has_const)    valc = '0;
    else if (has_regs) valc = const_long;
    else               valc = const_short;
  end
endmodule

// File: rtl/fd_nextpc.sv
module fd_nextpc
  import fd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  ilen,
  output logic [ADDR_W-1:0] next_pc
);
  assign next_pc = pc + {{(ADDR_W-LEN_W){1'b0}}, ilen};
endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
  import fd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [WIN_W-1:0]  window,
  output logic [3:0]        icode,
  output logic [3:0]        ifun,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [WORD_W-1:0] valc,
  output logic [LEN_W-1:0]  ilen,
  output logic [ADDR_W-1:0] next_pc,
  output logic              has_regs,
  output logic              has_const,
  output logic              bad_op
);
  assign icode = window[7:4];
  assign ifun  = window[3:0];

  fd_class u_class (
    .icode     (icode),
    .has_regs  (has_regs),
    .has_const (has_const),
    .bad_op    (bad_op),
    .ilen      (ilen)
  );

  fd_extract u_extract (
    .tail      (window[WIN_W-1:8]),
    .has_regs  (has_regs),
    .has_const (has_const),
    .ra        (ra),
    .rb        (rb),
    .valc      (valc)
  );

  fd_nextpc #(.ADDR_W(ADDR_W)) u_nextpc (
    .pc      (pc),
    .ilen    (ilen),
    .next_pc (next_pc)
  );
endmodule

// File: rtl/fetch_decode_chk.sv
module fetch_decode_chk
  import fd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic [ADDR_W-1:0] pc,
  input logic [WIN_W-1:0]  window,
  input logic [3:0]        icode,
  input logic [3:0]        ra,
  input logic [3:0]        rb,
  input logic [WORD_W-1:0] valc,
  input logic [LEN_W-1:0]  ilen,
  input logic [ADDR_W-1:0] next_pc,
  input logic              has_regs,
  input logic              has_const,
  input logic              bad_op
);
  always_comb begin
    p_opcode_byte0_r1: assert (icode == window[7:4]);
    p_len_range_r2: assert (ilen >= LEN_W'(1) && ilen <= LEN_W'(WIN_BYTES));
    p_noreg_none_r4: assert (has_regs || (ra == REG_NONE && rb == REG_NONE));
    p_noconst_zero_r7: assert (has_const || valc == '0);
    p_next_addr_r8: assert (next_pc - pc == {{(ADDR_W-LEN_W){1'b0}}, ilen});
    p_bad_clean_r9: assert (!bad_op || (!has_regs && !has_const && ilen == LEN_W'(1)));
    p_bad_range_r9: assert (bad_op == (icode > 4'hB));
  end
endmodule

bind fetch_decode fetch_decode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .pc        (pc),
  .window    (window),
  .icode     (icode),
  .ra        (ra),
  .rb        (rb),
  .valc      (valc),
  .ilen      (ilen),
  .next_pc   (next_pc),
  .has_regs  (has_regs),
  .has_const (has_const),
  .bad_op    (bad_op)
);

// File: tb/test_fetch_decode.sv
module test_fetch_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic [47:0] window = '0;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] valc, next_pc;
  logic [2:0]  ilen;
  logic        has_regs, has_const, bad_op;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  fetch_decode i_fetch_decode (
    .pc(pc), .window(window), .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
    .valc(valc), .ilen(ilen), .next_pc(next_pc), .has_regs(has_regs),
    .has_const(has_const), .bad_op(bad_op)
  );

  always @(posedge clk) begin
    if (rst_n) cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (pc=0x%0h win=0x%0h)", tag, act, exp, pc, window);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check_all();
    logic [3:0] op;
    logic [2:0] e_len;
    logic e_regs, e_const, e_bad;
    logic [31:0] e_valc;
    op = window[7:4];
    e_regs  = (op >= 4'h2 && op <= 4'h6) || op == 4'hA || op == 4'hB;
    e_const = (op >= 4'h3 && op <= 4'h5) || op == 4'h7 || op == 4'h8;
    e_bad   = op > 4'hB;
    case (op)
      4'h2, 4'h6, 4'hA, 4'hB: e_len = 3'd2;
      4'h7, 4'h8:             e_len = 3'd5;
      4'h3, 4'h4, 4'h5:       e_len = 3'd6;
      default:                e_len = 3'd1;
    endcase
    if (!e_const)    e_valc = 32'h0;
    else if (e_regs) e_valc = window[47:16];
    else             e_valc = window[39:8];
    chk(icode == window[7:4] && ifun == window[3:0], "R1", {24'h0, icode, ifun}, {24'h0, window[7:0]});
    chk(ilen == e_len, "R2", 32'(ilen), 32'(e_len));
    chk(has_regs == e_regs && has_const == e_const, "R10", {30'h0, has_regs, has_const}, {30'h0, e_regs, e_const});
    if (e_regs) chk(ra == window[15:12] && rb == window[11:8], "R3", {24'h0, ra, rb}, {24'h0, window[15:8]});
    else        chk(ra == 4'h8 && rb == 4'h8, "R4", {24'h0, ra, rb}, 32'h88);
    if (op == 4'h7 || op == 4'h8) chk(valc == e_valc, "R5", valc, e_valc);
    else if (e_const)             chk(valc == e_valc, "R6", valc, e_valc);
    else                          chk(valc == 32'h0, "R7", valc, 32'h0);
    chk(next_pc == pc + 32'(e_len), "R8", next_pc, pc + 32'(e_len));
    chk(bad_op == e_bad, "R9", 32'(bad_op), 32'(e_bad));
  endtask

  task automatic apply(input logic [31:0] p, input logic [47:0] w);
    @(negedge clk);
    pc = p;
    window = w;
    #2;
    check_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset-state inputs: all-zero window is a nop
    #1;
    chk(ilen == 3'd1 && next_pc == 32'h1 && !bad_op, "R2", 32'(ilen), 32'h1);
    // Known encodings
    apply(32'h100, 48'h0000_abcd_8230);
    chk(ra == 4'h8 && rb == 4'h2 && valc == 32'habcd && ilen == 3'd6, "R6", valc, 32'habcd);
    apply(32'h200, 48'h0000_0000_4320);
    chk(ra == 4'h4 && rb == 4'h3 && ilen == 3'd2 && valc == 32'h0, "R3", {24'h0, ra, rb}, 32'h43);
    apply(32'h300, 48'hffff_fff4_1550);
    chk(ra == 4'h1 && rb == 4'h5 && valc == 32'hffff_fff4, "R6", valc, 32'hffff_fff4);
    // jump absolute destination
    apply(32'hFFFF_FFFD, 48'h0012_3456_7873);
    chk(valc == 32'h1234_5678 && next_pc == 32'h2, "R5", valc, 32'h1234_5678);
    // sweep every opcode/function pair with scrambled trailing bytes
    for (int op = 0; op < 16; op++) begin
      for (int fn = 0; fn < 16; fn++) begin
        for (int k = 0; k < 4; k++) begin
          logic [47:0] w;
          logic [31:0] p;
          lfsr = step(lfsr);
          w[31:0] = lfsr;
          lfsr = step(lfsr);
          w[47:32] = lfsr[15:0];
          w[7:0] = {op[3:0], fn[3:0]};
          p = (k == 0) ? 32'hFFFF_FFFA + 32'(fn % 6) : lfsr;
          apply(p, w);
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule